// File: doc/BRIEF.md
# Dual-Mode Fetch and Branch Unit

This block holds the program counter and instruction register of a small 20-bit stack processor and walks through the four opcode slots of each instruction word. After reset it fetches one word per memory transaction. It then issues the slots one per cycle, oldest slot first, and fetches again when a branch is taken or the last slot has issued. Two fetch modes are available. In wide mode the whole 20-bit word comes from memory. In byte mode, used when booting from an 8-bit ROM, only the low byte comes from the ROM. The upper 12 bits of the word are the upper part of the address that is sitting on the shared address/data bus.

Every address leaving the block and every word entering it is XOR-scrambled with 0xAAAAA, and the unit removes this at its memory edge. Call, jump, jump-if-carry-clear and jump-if-top-zero all redirect the same way in any slot and in either mode. The low 10 bits of the program counter are replaced by the inverted low 10 bits of the instruction register, and the upper 10 bits are kept. A taken call also hands the return address to the return stack, which sits outside this block. In byte mode the low address bits of the fetch land in the third slot's opcode field, so whether a byte decodes as a branch depends on where it sits in memory.

Top module: `fb_fetch_unit`

## Requirements
- R1: While `rst_n` is low, the program counter P is cleared, `boot_byte_mode` is captured as the fetch mode, and `mem_rd`, `op_valid`, `br_taken` and `ret_push` are all low. The first fetch after reset is from plain address 0.
- R2: `mem_addr` equals P XOR 0xAAAAA. In wide mode the instruction word is `mem_rdata` XOR 0xAAAAA.
- R3: In byte mode the instruction word is {P[19:8], `mem_rdata[7:0]` XOR 0xAA}. `mem_rdata[19:8]` has no effect.
- R4: P increments by one with every accepted fetch, in both modes.
- R5: A fetch holds `mem_rd` and a stable `mem_addr` until `mem_ready` is seen high at a clock edge. No slot issues (`op_valid` low) until the fetched word has been latched.
- R6: Slots issue one per cycle in the order bits [19:15], [14:10], [9:5], [4:0]. `op_slot` is 0 to 3 and `op_code` is the slot's 5-bit opcode. Opcodes: 0x00 no-op, 0x02 jump, 0x03 call, 0x04 jump if carry clear, 0x05 jump if top-of-stack zero. Every other value is a non-branch.
- R7: A taken branch in any slot and either mode pulses `br_taken`. It sets P[9:0] to the bitwise inverse of I[9:0], keeps P[19:10], discards the remaining slots, and the next fetch is from the new P.
- R8: Jump-if-carry-clear is taken only when `carry_in` is 0, and jump-if-top-zero only when `tos_zero` is 1. When it is not taken, issue continues with the next slot, or with a fetch of P if it was the last slot.
- R9: A taken call pulses `ret_push` for one cycle, with `ret_addr` equal to P before the override. This is the address of the word after the call's word.
- R10: In byte mode, bits [9:8] of the third slot's opcode are P[9:8] of the fetch address. A ROM byte that decodes as a branch when fetched with P[9:8]=00 is a non-branch when fetched with P[9:8]=11. Its opcode bits also form part of its own target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_byte_mode | input | 1 | Fetch mode sampled during reset: 1 selects byte mode |
| mem_addr | output | 20 | Scrambled fetch address |
| mem_rd | output | 1 | Fetch request, held until ready |
| mem_ready | input | 1 | Memory has valid data this cycle |
| mem_rdata | input | 20 | Scrambled read data (byte mode uses bits 7:0 only) |
| carry_in | input | 1 | Carry flag from the datapath |
| tos_zero | input | 1 | Top of data stack is zero |
| op_valid | output | 1 | A slot issues this cycle |
| op_slot | output | 2 | Index of the issuing slot |
| op_code | output | 5 | Opcode of the issuing slot |
| br_taken | output | 1 | Issuing slot redirects the program counter |
| ret_push | output | 1 | Push ret_addr onto the return stack |
| ret_addr | output | 20 | Return address for a taken call |

## Verification
The hardest cases to reach are fetches where P has nonzero bits above bit 7. P always starts at 0, and only those fetches show that the upper bits of P survive a branch and that byte-mode opcodes depend on the fetch address. The stimulus reaches them by branching first. One case jumps in byte mode to 0x3BF and places there the byte that decodes as a call at address 0, then checks that it issues as a non-branch. Another jumps in wide mode to 0x3FF and lets the increment carry P into 0x400 before a second jump. Elsewhere a table covers a branch in each slot of each mode, taken and not-taken conditions, and varied memory latency.

// File: rtl/fb_pkg.sv
package fb_pkg;

    localparam int OP_W = 5;

    typedef logic [OP_W-1:0] opcode_t;

    localparam opcode_t OPC_NOP  = 5'h00;
    localparam opcode_t OPC_JMP  = 5'h02;
    localparam opcode_t OPC_CALL = 5'h03;
    localparam opcode_t OPC_JCC  = 5'h04;
    localparam opcode_t OPC_JTZ  = 5'h05;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_FETCH,
        FS_EXEC
    } fs_state_t;

endpackage

// File: rtl/fb_word_former.sv
// Builds the plain instruction word from the memory return in either fetch mode.
module fb_word_former #(
    parameter int              WORD_W   = 20,
    parameter int              BYTE_W   = 8,
    parameter logic [WORD_W-1:0] SCRAMBLE = 20'hAAAAA,
    localparam int             HI_W     = WORD_W - BYTE_W
) (
    input  logic              byte_mode,
    input  logic [HI_W-1:0]   p_hi,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] wide_word;
    logic [WORD_W-1:0] narrow_word;

    assign wide_word   = rdata ^ SCRAMBLE;
    // Upper part is the bus address (descrambled that is P itself); low part is the ROM byte.
    assign narrow_word = {p_hi, rdata[BYTE_W-1:0] ^ SCRAMBLE[BYTE_W-1:0]};

    assign word = byte_mode ? narrow_word : wide_word;

endmodule

// File: rtl/fb_branch_unit.sv
// Slot decode, condition evaluation and branch target formation.
module fb_branch_unit
    import fb_pkg::*;
#(
    parameter int  WORD_W = 20,
    parameter int  NSLOT  = 4,
    parameter int  TGT_W  = 10,
    localparam int IDX_W  = $clog2(NSLOT)
) (
    input  logic                    [WORD_W-1:0] ir,
    input  logic                    [IDX_W-1:0]  slot,
    input  logic             [WORD_W-TGT_W-1:0]  p_hi,
    input  logic                                 carry_in,
    input  logic                                 tos_zero,
    output opcode_t                              op,
    output logic                                 taken,
    output logic                                 is_call,
    output logic                    [WORD_W-1:0] p_branch
);

    opcode_t fields [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign fields[g] = ir[WORD_W-1-g*OP_W -: OP_W];
    end

    assign op = fields[slot];

    always_comb begin
        unique case (op)
            OPC_JMP, OPC_CALL: taken = 1'b1;
            OPC_JCC:           taken = !carry_in;
            OPC_JTZ:           taken = tos_zero;
            default:           taken = 1'b0;
        endcase
    end

    assign is_call  = (op == OPC_CALL);
    assign p_branch = {p_hi, ~ir[TGT_W-1:0]};

endmodule

// File: rtl/fb_fetch_unit.sv
// Program counter, instruction register and slot sequencer.
module fb_fetch_unit
    import fb_pkg::*;
#(
    parameter int                WORD_W   = 20,
    parameter int                NSLOT    = 4,
    parameter int                TGT_W    = 10,
    parameter int                BYTE_W   = 8,
    parameter logic [WORD_W-1:0] SCRAMBLE = 20'hAAAAA,
    localparam int               IDX_W    = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_byte_mode,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              carry_in,
    input  logic              tos_zero,
    output logic              op_valid,
    output logic [IDX_W-1:0]  op_slot,
    output logic [OP_W-1:0]   op_code,
    output logic              br_taken,
    output logic              ret_push,
    output logic [WORD_W-1:0] ret_addr
);

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NSLOT - 1);

    fs_state_t         state_q, state_d;
    logic [WORD_W-1:0] p_q;
    logic [WORD_W-1:0] ir_q;
    logic [IDX_W-1:0]  slot_q;
    logic              byte_mode_q;

    logic [WORD_W-1:0] fetched_word;
    opcode_t           dec_op;
    logic              dec_taken;
    logic              dec_call;
    logic [WORD_W-1:0] p_target;
    logic              redirect;

    fb_word_former #(
        .WORD_W  (WORD_W),
        .BYTE_W  (BYTE_W),
        .SCRAMBLE(SCRAMBLE)
    ) u_former (
        .byte_mode(byte_mode_q),
        .p_hi     (p_q[WORD_W-1:BYTE_W]),
        .rdata    (mem_rdata),
        .word     (fetched_word)
    );

    fb_branch_unit #(
        .WORD_W(WORD_W),
        .NSLOT (NSLOT),
        .TGT_W (TGT_W)
    ) u_branch (
        .ir      (ir_q),
        .slot    (slot_q),
        .p_hi    (p_q[WORD_W-1:TGT_W]),
        .carry_in(carry_in),
        .tos_zero(tos_zero),
        .op      (dec_op),
        .taken   (dec_taken),
        .is_call (dec_call),
        .p_branch(p_target)
    );

    assign redirect = (state_q == FS_EXEC) && dec_taken;

    // Transitions: IDLE->FETCH always; FETCH->EXEC on ready; EXEC->FETCH on redirect or last slot.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:  state_d = FS_FETCH;
            FS_FETCH: if (mem_ready) state_d = FS_EXEC;
            FS_EXEC:  if (dec_taken || slot_q == LAST_SLOT) state_d = FS_FETCH;
            default:  state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= FS_IDLE;
            p_q         <= '0;
            ir_q        <= '0;
            slot_q      <= '0;
            byte_mode_q <= boot_byte_mode;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                FS_FETCH: begin
                    if (mem_ready) begin
                        ir_q   <= fetched_word;
                        p_q    <= p_q + WORD_W'(1);
                        slot_q <= '0;
                    end
                end
                FS_EXEC: begin
                    if (dec_taken) p_q    <= p_target;
                    else           slot_q <= slot_q + IDX_W'(1);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_rd   = (state_q == FS_FETCH);
        mem_addr = p_q ^ SCRAMBLE;
        op_valid = (state_q == FS_EXEC);
        op_slot  = slot_q;
        op_code  = dec_op;
        br_taken = redirect;
        ret_push = redirect && dec_call;
        ret_addr = p_q;
    end

endmodule

// File: rtl/fb_fetch_chk.sv
module fb_fetch_chk
    import fb_pkg::*;
#(
    parameter int                WORD_W   = 20,
    parameter logic [WORD_W-1:0] SCRAMBLE = 20'hAAAAA
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_ready,
    input logic              carry_in,
    input logic              tos_zero,
    input logic              op_valid,
    input logic [1:0]        op_slot,
    input logic [OP_W-1:0]   op_code,
    input logic              br_taken,
    input logic              ret_push,
    input logic [WORD_W-1:0] ret_addr
);

    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_ready) |=> ((mem_addr ^ SCRAMBLE) == (($past(mem_addr) ^ SCRAMBLE) + WORD_W'(1))))
        else $error("fetch step"); // R4

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)))
        else $error("fetch hold"); // R5

    AST_NO_ISSUE_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !op_valid)
        else $error("issue during fetch"); // R5

    AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !br_taken && op_slot != 2'd3) |=> (op_valid && op_slot == $past(op_slot) + 2'd1))
        else $error("slot order"); // R6

    AST_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (mem_rd && mem_addr[WORD_W-1:10] == $past(mem_addr[WORD_W-1:10])))
        else $error("high bits"); // R7

    AST_JCC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OPC_JCC && carry_in) |-> !br_taken)
        else $error("jcc"); // R8

    AST_JTZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OPC_JTZ && !tos_zero) |-> !br_taken)
        else $error("jtz"); // R8

    AST_PUSH_IS_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        ret_push |-> (br_taken && op_code == OPC_CALL))
        else $error("push without call"); // R9

    AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ret_push |-> (ret_addr == (mem_addr ^ SCRAMBLE)))
        else $error("return address"); // R9

    AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_push |=> !ret_push)
        else $error("push pulse"); // R9

endmodule

bind fb_fetch_unit fb_fetch_chk #(
    .WORD_W  (WORD_W),
    .SCRAMBLE(SCRAMBLE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_ready(mem_ready),
    .carry_in (carry_in),
    .tos_zero (tos_zero),
    .op_valid (op_valid),
    .op_slot  (op_slot),
    .op_code  (op_code),
    .br_taken (br_taken),
    .ret_push (ret_push),
    .ret_addr (ret_addr)
);

// File: tb/sim_fb_fetch_unit.sv
module sim_fb_fetch_unit;

    localparam logic [19:0] SCR = 20'hAAAAA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_byte_mode = 1'b0;
    logic [19:0] mem_addr;
    logic        mem_rd;
    logic        mem_ready = 1'b0;
    logic [19:0] mem_rdata = '0;
    logic        carry_in = 1'b0;
    logic        tos_zero = 1'b0;
    logic        op_valid;
    logic [1:0]  op_slot;
    logic [4:0]  op_code;
    logic        br_taken;
    logic        ret_push;
    logic [19:0] ret_addr;

    always #2 clk = ~clk;

    fb_fetch_unit u0 (
        .clk(clk), .rst_n(rst_n), .boot_byte_mode(boot_byte_mode),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .carry_in(carry_in), .tos_zero(tos_zero),
        .op_valid(op_valid), .op_slot(op_slot), .op_code(op_code),
        .br_taken(br_taken), .ret_push(ret_push), .ret_addr(ret_addr)
    );

    typedef struct packed {
        logic        mode;
        logic [19:0] word;
        logic        carry;
        logic        tz;
        logic [19:0] exp_next;
        logic        exp_call;
        logic [2:0]  exp_ops;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 20'h14555, 1'b0, 1'b0, 20'h002AA, 1'b0, 3'd1},
        '{1'b0, 20'h88FE0, 1'b0, 1'b0, 20'h0001F, 1'b1, 3'd2},
        '{1'b0, 20'h00087, 1'b0, 1'b0, 20'h00378, 1'b0, 3'd3},
        '{1'b0, 20'h00087, 1'b1, 1'b0, 20'h00001, 1'b0, 3'd4},
        '{1'b0, 20'h8C625, 1'b0, 1'b1, 20'h001DA, 1'b0, 3'd4},
        '{1'b0, 20'h2C45E, 1'b0, 1'b0, 20'h003A1, 1'b0, 3'd3},
        '{1'b0, 20'h8C631, 1'b0, 1'b0, 20'h00001, 1'b0, 3'd4},
        '{1'b0, 20'h00003, 1'b0, 1'b0, 20'h003FC, 1'b1, 3'd4},
        '{1'b1, 20'h00040, 1'b0, 1'b0, 20'h003BF, 1'b0, 3'd3},
        '{1'b1, 20'h0006A, 1'b0, 1'b0, 20'h00395, 1'b1, 3'd3},
        '{1'b1, 20'h00085, 1'b0, 1'b0, 20'h0037A, 1'b0, 3'd3},
        '{1'b1, 20'h00085, 1'b1, 1'b0, 20'h00001, 1'b0, 3'd4},
        '{1'b1, 20'h000A3, 1'b0, 1'b1, 20'h0035C, 1'b0, 3'd3},
        '{1'b1, 20'h00023, 1'b0, 1'b0, 20'h003DC, 1'b1, 3'd4},
        '{1'b1, 20'h00012, 1'b0, 1'b0, 20'h00001, 1'b0, 3'd4}
    };

    logic [19:0] mem_w [0:2047];
    int          lat = 0;
    int          lat_cnt = 0;
    int          fcnt = 0;
    int          exec_cnt = 0;
    int          push_cnt = 0;
    int          stall_bad = 0;
    logic [19:0] last_ret = '0;
    logic [19:0] prev_addr = '0;
    logic        prev_rd = 1'b0;
    logic [19:0] f_addr [8];
    int          f_ops [8];
    int          f_push [8];
    int          n_tests = 0;
    int          n_fail = 0;

    // Memory model and monitor, all on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            fcnt = 0; exec_cnt = 0; push_cnt = 0; lat_cnt = 0; stall_bad = 0;
            mem_ready = 1'b0; prev_rd = 1'b0;
        end else begin
            if (op_valid) exec_cnt++;
            if (ret_push) begin push_cnt++; last_ret = ret_addr; end
            if (prev_rd && mem_rd && mem_addr != prev_addr) stall_bad++;
            if (op_valid && mem_rd) stall_bad++;
            prev_rd = mem_rd && !mem_ready;
            prev_addr = mem_addr;
            if (mem_ready) begin
                mem_ready = 1'b0;
            end else if (mem_rd) begin
                if (lat_cnt >= lat) begin
                    if (boot_byte_mode)
                        mem_rdata = {12'h5A5, mem_w[(mem_addr ^ SCR) & 20'h7FF][7:0] ^ 8'hAA};
                    else
                        mem_rdata = mem_w[(mem_addr ^ SCR) & 20'h7FF] ^ SCR;
                    mem_ready = 1'b1;
                    lat_cnt = 0;
                    if (fcnt < 8) begin
                        f_addr[fcnt] = mem_addr ^ SCR;
                        f_ops[fcnt]  = exec_cnt;
                        f_push[fcnt] = push_cnt;
                    end
                    fcnt++;
                end else begin
                    lat_cnt++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int a = 0; a < 2048; a++) mem_w[a] = 20'h0;
    endtask

    task automatic start(input logic mode, input logic c, input logic z);
        @(negedge clk);
        rst_n = 1'b0;
        boot_byte_mode = mode;
        carry_in = c;
        tos_zero = z;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_fetches(input int n);
        for (int g = 0; g < 3000 && fcnt < n; g++) @(negedge clk);
        if (fcnt < n) begin
            n_tests++; n_fail++;
            $display("FAIL timeout waiting for fetch %0d, got %0d", n, fcnt);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: outputs quiet during reset, first fetch at scrambled 0
        clear_mem();
        lat = 0;
        @(negedge clk);
        rst_n = 1'b0;
        boot_byte_mode = 1'b0;
        repeat (2) @(negedge clk);
        check(!mem_rd && !op_valid && !br_taken && !ret_push, "R1 quiet in reset",
              {16'h0, mem_rd, op_valid, br_taken, ret_push}, 20'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_rd && mem_addr == 20'hAAAAA, "R1 R2 first fetch address", mem_addr, 20'hAAAAA);

        // Table of branch cases from every slot in both modes
        for (int i = 0; i < NV; i++) begin
            clear_mem();
            mem_w[0] = VECS[i].word;
            lat = i % 3;
            start(VECS[i].mode, VECS[i].carry, VECS[i].tz);
            wait_fetches(2);
            check(f_addr[0] == 20'h0, $sformatf("R1 vec%0d boot address", i), f_addr[0], 20'h0);
            check(f_addr[1] == VECS[i].exp_next,
                  $sformatf("R7 R8 %s vec%0d next fetch", VECS[i].mode ? "R3 byte" : "R2 wide", i),
                  f_addr[1], VECS[i].exp_next);
            check(f_ops[1] == int'(VECS[i].exp_ops), $sformatf("R6 vec%0d slots issued", i),
                  20'(f_ops[1]), 20'(VECS[i].exp_ops));
            check(f_push[1] == int'(VECS[i].exp_call), $sformatf("R9 vec%0d push count", i),
                  20'(f_push[1]), 20'(VECS[i].exp_call));
            if (VECS[i].exp_call)
                check(last_ret == 20'h1, $sformatf("R9 vec%0d return address", i), last_ret, 20'h1);
        end

        // R10: byte-mode aliasing once P[9:8] is nonzero
        clear_mem();
        mem_w[0]     = 20'h00040;
        mem_w[20'h3BF] = 20'h00060;
        mem_w[20'h3C0] = 20'h0006A;
        lat = 1;
        start(1'b1, 1'b0, 1'b0);
        wait_fetches(4);
        check(f_addr[1] == 20'h3BF, "R10 jump into upper page", f_addr[1], 20'h3BF);
        check(f_addr[2] == 20'h3C0, "R10 call byte not a branch at P[9:8]=11", f_addr[2], 20'h3C0);
        check(f_addr[3] == 20'h3C1, "R10 R4 sequential step", f_addr[3], 20'h3C1);
        check(f_push[3] == 0, "R10 no return push", 20'(f_push[3]), 20'h0);

        // R7: upper bits of P kept across a branch, reached by crossing 0x400
        clear_mem();
        mem_w[0]       = 20'h10000;
        mem_w[20'h400] = 20'h88AAA;
        lat = 0;
        start(1'b0, 1'b0, 1'b0);
        wait_fetches(4);
        check(f_addr[1] == 20'h3FF, "R7 jump to 3FF", f_addr[1], 20'h3FF);
        check(f_addr[2] == 20'h400, "R4 increment carries into bit 10", f_addr[2], 20'h400);
        check(f_addr[3] == 20'h555, "R7 high bits kept", f_addr[3], 20'h555);

        // R5: long memory latency, address held and no issue before data
        clear_mem();
        mem_w[0] = 20'h88FE0;
        lat = 7;
        start(1'b0, 1'b0, 1'b0);
        wait_fetches(2);
        check(f_ops[0] == 0, "R5 no issue before first word", 20'(f_ops[0]), 20'h0);
        check(f_addr[1] == 20'h0001F && f_ops[1] == 2, "R5 call after stall", f_addr[1], 20'h0001F);
        check(stall_bad == 0, "R5 stall stability", 20'(stall_bad), 20'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule